// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit timing of a CAN receiver. A programmable divider produces time-quantum ticks. A quantum counter then walks each bit through three parts: a one-quantum synchronization part, a first phase part and a second phase part. The unit raises a one-cycle sample strobe where the first phase part ends and registers the receive line at that point. It raises a one-cycle bit-end strobe where the second phase part ends.

When the bus is idle, a falling edge on the receive line (recessive to dominant) restarts the bit from its synchronization quantum. This is hard synchronization. While a frame is in progress, one falling edge per bit shifts the sample point to follow the transmitter. An edge that falls in the first phase part lengthens that part. An edge that falls in the second phase part shortens that part. Either adjustment is capped at the programmed jump width. A configuration outside the legal ranges is flagged and holds the unit inactive. The surrounding receiver uses the strobes and the sampled bit to decode frames.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `presc_i + 1` clock cycles, where `presc_i` is a 10-bit field (0..1023, so divisors 1..1024).
- R2: `cfg_err_o` is high exactly when the configuration is illegal: `tseg1_i` outside 4..16, `tseg2_i` outside 2..8, `sjw_i` outside 1..4, or 1 + `tseg1_i` + `tseg2_i` outside 8..25. While it is high, `sample_o` and `bit_end_o` stay low.
- R3: Hard synchronization uses P = `presc_i` + 1. Let E be the clock edge at which `rx_i` is first captured low after being high, with `idle_i` high. `sample_o` is high in the single cycle after edge E + P·(1 + `tseg1_i`). `bit_end_o` is high in the single cycle after edge E + P·(1 + `tseg1_i` + `tseg2_i`).
- R4: Without edges, successive bit-end strobes are P·(1 + `tseg1_i` + `tseg2_i`) cycles apart, and so are successive sample strobes.
- R5: `rx_bit_o` resets to 1. It changes only at the clock edge that ends a `sample_o` cycle, and then takes the `rx_i` level captured at the edge that began that cycle.
- R6: With `idle_i` low, a falling edge detected during quantum c of the first phase part (c counted from 1) lengthens that part by min(c, `sjw_i`) quanta.
- R7: With `idle_i` low, a falling edge detected during quantum c of the second phase part makes that part end after quantum max(c, `tseg2_i` − `sjw_i`).
- R8: A falling edge detected during the synchronization quantum with `idle_i` low leaves the bit timing unchanged.
- R9: `sample_o` and `bit_end_o` are never high together, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_i | input | 10 | Quantum divider minus one |
| tseg1_i | input | 5 | First phase part length in quanta |
| tseg2_i | input | 4 | Second phase part length in quanta |
| sjw_i | input | 3 | Resynchronization jump width in quanta |
| rx_i | input | 1 | Receive line, 1 = recessive |
| idle_i | input | 1 | Bus idle: edges hard-synchronize |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| bit_end_o | output | 1 | One-cycle strobe at the end of each bit |
| rx_bit_o | output | 1 | Receive level registered at the sample point |
| cfg_err_o | output | 1 | Illegal configuration, unit held inactive |

## Verification
The receive line passes through two registers before its edge is seen. A hard synchronization therefore completes one clock after the capturing edge. From then on, the sample strobe is due exactly P·(1+`tseg1_i`) clocks after the capturing edge, and the bit-end strobe exactly P·(1+`tseg1_i`+`tseg2_i`) clocks after it. Each scenario counts clock edges from the negative edge that drives the falling receive level. It records the exact cycle in which each strobe is seen, reading outputs at negative edges. It then compares these cycles with the requirement formulas. A resynchronizing edge is placed by driving `rx_i` one cycle before the target quantum. The sampled bit is read in the cycle after its strobe.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_cfg_check.sv
module cbt_cfg_check #(
  parameter int T1_W    = 5,
  parameter int T2_W    = 4,
  parameter int SJW_W   = 3,
  parameter int T1_MIN  = 4,
  parameter int T1_MAX  = 16,
  parameter int T2_MIN  = 2,
  parameter int T2_MAX  = 8,
  parameter int SJW_MIN = 1,
  parameter int SJW_MAX = 4,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             err_o
);
  localparam int TOT_W = ((T1_W > T2_W) ? T1_W : T2_W) + 2;

  logic [TOT_W-1:0] total;
  logic bad_t1, bad_t2, bad_sjw, bad_tot;

  always_comb begin
    total   = TOT_W'(1) + TOT_W'(tseg1_i) + TOT_W'(tseg2_i);
    bad_t1  = (tseg1_i < T1_W'(T1_MIN)) || (tseg1_i > T1_W'(T1_MAX));
    bad_t2  = (tseg2_i < T2_W'(T2_MIN)) || (tseg2_i > T2_W'(T2_MAX));
    bad_sjw = (sjw_i < SJW_W'(SJW_MIN)) || (sjw_i > SJW_W'(SJW_MAX));
    bad_tot = (total < TOT_W'(BIT_MIN)) || (total > TOT_W'(BIT_MAX));
    err_o   = bad_t1 | bad_t2 | bad_sjw | bad_tot;
  end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int PRESC_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] div_m1_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = en_i & (cnt_q >= div_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || restart_i)  cnt_q <= '0;
    else if (cnt_q >= div_m1_i)   cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_m1_i != '0 && !restart_i) |=> (!tick_o || div_m1_i == '0));
endmodule

// File: rtl/cbt_rx_edge.sv
module cbt_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o
);
  logic rx_q, rx_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      rx_q <= rx_i;
      rx_p <= rx_q;
    end
  end

  assign rx_o   = rx_q;
  assign fall_o = rx_p & ~rx_q;
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import can_bt_pkg::*;
#(
  parameter int T1_W    = 5,
  parameter int T2_W    = 4,
  parameter int SJW_W   = 3,
  parameter int T1_MAX  = 16,
  parameter int T2_MAX  = 8,
  parameter int SJW_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             idle_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             hard_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  localparam int CNT_W = ((T1_W > T2_W) ? T1_W : T2_W) + 2;

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q, lim1_q, lim2_q;
  logic             rs_ok_q;

  logic [CNT_W-1:0] sjw_w, pe1, lim1_eff, lim2_eff;
  logic             rs1, rs2;

  always_comb begin
    sjw_w  = CNT_W'(sjw_i);
    hard_o = en_i & fall_i & idle_i;
    rs1    = en_i & fall_i & ~idle_i & rs_ok_q & (seg_q == SEG_ONE);
    rs2    = en_i & fall_i & ~idle_i & rs_ok_q & (seg_q == SEG_TWO);
    pe1    = (cnt_q < sjw_w) ? cnt_q : sjw_w;
    lim1_eff = rs1 ? (lim1_q + pe1) : lim1_q;
    // shortened end is max(current quantum, nominal - sjw)
    if (rs2) lim2_eff = (lim2_q > cnt_q + sjw_w) ? (lim2_q - sjw_w) : cnt_q;
    else     lim2_eff = lim2_q;
    sample_o  = en_i & tick_i & ~hard_o & (seg_q == SEG_ONE) & (cnt_q >= lim1_eff);
    bit_end_o = en_i & tick_i & ~hard_o & (seg_q == SEG_TWO) & (cnt_q >= lim2_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= SEG_SYNC;
      cnt_q   <= '0;
      lim1_q  <= '0;
      lim2_q  <= '0;
      rs_ok_q <= 1'b1;
    end else if (!en_i || hard_o) begin
      seg_q   <= SEG_SYNC;
      cnt_q   <= '0;
      rs_ok_q <= 1'b1;
    end else begin
      if (rs1) begin
        lim1_q  <= lim1_eff;
        rs_ok_q <= 1'b0;
      end
      if (rs2) begin
        lim2_q  <= lim2_eff;
        rs_ok_q <= 1'b0;
      end
      if (tick_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q  <= SEG_ONE;
            cnt_q  <= CNT_W'(1);
            lim1_q <= CNT_W'(tseg1_i);
            lim2_q <= CNT_W'(tseg2_i);
          end
          SEG_ONE: begin
            if (cnt_q >= lim1_eff) begin
              seg_q <= SEG_TWO;
              cnt_q <= CNT_W'(1);
            end else cnt_q <= cnt_q + 1'b1;
          end
          SEG_TWO: begin
            if (cnt_q >= lim2_eff) begin
              seg_q   <= SEG_SYNC;
              cnt_q   <= '0;
              rs_ok_q <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: seg_q <= SEG_SYNC;
        endcase
      end
    end
  end

  // R6
  seg1_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_ONE) |-> (cnt_q <= CNT_W'(T1_MAX + SJW_MAX)));
  // R7
  seg2_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_TWO) |-> (cnt_q <= CNT_W'(T2_MAX)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 10,
  parameter int T1_W    = 5,
  parameter int T2_W    = 4,
  parameter int SJW_W   = 3,
  parameter int T1_MIN  = 4,
  parameter int T1_MAX  = 16,
  parameter int T2_MIN  = 2,
  parameter int T2_MAX  = 8,
  parameter int SJW_MIN = 1,
  parameter int SJW_MAX = 4,
  parameter int BIT_MIN = 8,
  parameter int BIT_MAX = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [T1_W-1:0]    tseg1_i,
  input  logic [T2_W-1:0]    tseg2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  input  logic               rx_i,
  input  logic               idle_i,
  output logic               sample_o,
  output logic               bit_end_o,
  output logic               rx_bit_o,
  output logic               cfg_err_o
);
  logic en, tick, rx_s, fall, hard, rx_bit_q;

  cbt_cfg_check #(
    .T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W),
    .T1_MIN(T1_MIN), .T1_MAX(T1_MAX), .T2_MIN(T2_MIN), .T2_MAX(T2_MAX),
    .SJW_MIN(SJW_MIN), .SJW_MAX(SJW_MAX), .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX)
  ) u_cfg (
    .tseg1_i(tseg1_i), .tseg2_i(tseg2_i), .sjw_i(sjw_i), .err_o(cfg_err_o)
  );

  assign en = ~cfg_err_o;

  cbt_rx_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .rx_o(rx_s), .fall_o(fall)
  );

  cbt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .restart_i(hard),
    .div_m1_i(presc_i), .tick_o(tick)
  );

  cbt_seq #(
    .T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W),
    .T1_MAX(T1_MAX), .T2_MAX(T2_MAX), .SJW_MAX(SJW_MAX)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .tick_i(tick), .fall_i(fall),
    .idle_i(idle_i), .tseg1_i(tseg1_i), .tseg2_i(tseg2_i), .sjw_i(sjw_i),
    .hard_o(hard), .sample_o(sample_o), .bit_end_o(bit_end_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_bit_q <= 1'b1;
    else if (sample_o) rx_bit_q <= rx_s;
  end
  assign rx_bit_o = rx_bit_q;

  // R2
  cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!sample_o && !bit_end_o));
  // R3
  hard_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |=> !sample_o && !bit_end_o);
  // R5
  rx_bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |=> $stable(rx_bit_o));
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, bit_end_o}));
  // R9
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  // R9
  bit_end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> !bit_end_o);
endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] presc = '0;
  logic [4:0] tseg1 = 5'd6;
  logic [3:0] tseg2 = 4'd3;
  logic [2:0] sjw = 3'd1;
  logic       rx = 1'b1;
  logic       idle = 1'b1;
  logic       sample, bit_end, rx_bit, cfg_err;

  int total = 0;
  int bad = 0;
  int s1, s2, e1, e2, b1, b2, nsamp, nend;

  always #4 clk = ~clk;

  can_bit_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc), .tseg1_i(tseg1),
    .tseg2_i(tseg2), .sjw_i(sjw), .rx_i(rx), .idle_i(idle),
    .sample_o(sample), .bit_end_o(bit_end), .rx_bit_o(rx_bit), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Hard sync at n=0; optional rise and second fall; records strobe cycles.
  task automatic run_seq(input int pr, input int t1, input int t2, input int sj,
                         input bit go_busy, input int m_rise, input int m_fall,
                         input int ncyc);
    bit prev_s;
    presc = 10'(pr); tseg1 = 5'(t1); tseg2 = 4'(t2); sjw = 3'(sj);
    idle = 1'b1; rx = 1'b1;
    repeat (3) @(negedge clk);
    rx = 1'b0;
    s1 = -1; s2 = -1; e1 = -1; e2 = -1; b1 = -1; b2 = -1;
    nsamp = 0; nend = 0; prev_s = 1'b0;
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        if (prev_s) begin
          if (nsamp == 1) b1 = int'(rx_bit);
          else if (nsamp == 2) b2 = int'(rx_bit);
        end
        prev_s = sample;
        if (sample) begin
          nsamp++;
          if (nsamp == 1) s1 = n; else if (nsamp == 2) s2 = n;
        end
        if (bit_end) begin
          nend++;
          if (nend == 1) e1 = n; else if (nend == 2) e2 = n;
        end
      end
      if (go_busy && n == 2) idle = 1'b0;
      if (n == m_rise) rx = 1'b1;
      if (n == m_fall) rx = 1'b0;
    end
  endtask

  task automatic test_reset();
    chk("R5 rx_bit reset", int'(rx_bit), 1);
    chk("R9 sample reset", int'(sample), 0);
    chk("R9 bit_end reset", int'(bit_end), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 default cfg ok", int'(cfg_err), 0);
  endtask

  task automatic cfg_case(input int t1, input int t2, input int sj, input int exp_err);
    int strobes = 0;
    tseg1 = 5'(t1); tseg2 = 4'(t2); sjw = 3'(sj); presc = '0;
    idle = 1'b1;
    @(negedge clk);
    chk("R2 cfg_err", int'(cfg_err), exp_err);
    if (exp_err == 1) begin
      for (int i = 0; i < 40; i++) begin
        rx = (i % 7) > 2;
        @(negedge clk);
        if (sample || bit_end) strobes++;
      end
      chk("R2 held inactive", strobes, 0);
      rx = 1'b1;
    end
  endtask

  task automatic test_cfg();
    cfg_case(4, 2, 1, 1);
    cfg_case(4, 3, 1, 0);
    cfg_case(16, 8, 4, 0);
    cfg_case(3, 8, 1, 1);
    cfg_case(17, 4, 1, 1);
    cfg_case(8, 9, 1, 1);
    cfg_case(8, 4, 0, 1);
    cfg_case(8, 4, 5, 1);
  endtask

  task automatic test_hard_div1();
    run_seq(0, 6, 3, 1, 1'b0, -1, -1, 30);
    chk("R3 sample div1", s1, 8);
    chk("R3 bit_end div1", e1, 11);
    chk("R5 sampled dominant", b1, 0);
    chk("R4 period div1", e2 - e1, 10);
  endtask

  task automatic test_hard_div3();
    run_seq(2, 4, 3, 2, 1'b0, -1, -1, 60);
    chk("R1 R3 sample div3", s1, 16);
    chk("R1 R3 bit_end div3", e1, 25);
    chk("R4 bit period div3", e2 - e1, 24);
    chk("R4 sample period div3", s2 - s1, 24);
  endtask

  task automatic test_hard_divmax();
    run_seq(1023, 4, 3, 1, 1'b0, -1, -1, 8200);
    chk("R1 sample div1024", s1, 5121);
    chk("R1 bit_end div1024", e1, 8193);
  endtask

  // Bit 2 starts its sync quantum at n=12 for t1=6,t2=3.
  task automatic test_resync_seg1();
    run_seq(0, 6, 3, 2, 1'b1, 3, 12, 30);
    chk("R5 sampled recessive", b1, 1);
    chk("R6 lengthen by 1", s2, 19);
    chk("R6 bit_end after lengthen", e2, 22);
    chk("R5 sampled dominant bit2", b2, 0);
    run_seq(0, 6, 3, 2, 1'b1, 3, 14, 30);
    chk("R6 lengthen capped at sjw", s2, 20);
    chk("R6 bit_end capped", e2, 23);
  endtask

  task automatic test_resync_seg2();
    run_seq(0, 6, 3, 2, 1'b1, 3, 18, 30);
    chk("R7 sample unchanged", s2, 18);
    chk("R7 shorten sjw2", e2, 19);
    run_seq(0, 6, 3, 1, 1'b1, 3, 18, 30);
    chk("R7 shorten capped sjw1", e2, 20);
  endtask

  task automatic test_sync_edge();
    run_seq(0, 6, 3, 2, 1'b1, 3, 11, 30);
    chk("R8 sample unchanged", s2, 18);
    chk("R8 bit_end unchanged", e2, 21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_cfg();
    test_hard_div1();
    test_hard_div3();
    test_hard_divmax();
    test_resync_seg1();
    test_resync_seg2();
    test_sync_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule